// File: doc/BRIEF.md
# Frequency Select Watchdog Controller

This block decides which 5-bit frequency-select code drives the clock synthesizer, and it watches that choice with a watchdog timer. In normal operation the code comes from one of two places: hardware select pins, which are sampled while the active-low power-good strobe is low, or a code that software has written into a register. Software enables the watchdog and keeps it alive by writing the timer count field. If software stops doing this, the timer expires after the programmed number of ticks of roughly 290 ms.

When the timer expires, the block sets a sticky alarm flag. It then replaces the active code with a safe code and pulls an active-low system reset line low for a fixed number of ticks. The safe code is either the latched pin value or a programmed safe field. A master program-enable bit gates the programmed overrides. An optional mode also pulses the reset line whenever the active code changes.

All control fields arrive as plain inputs from a register file that sits outside this block. That register file holds the power-up values: a count of 8 and a safe field of 01111. A prescaler derives the tick from the reference clock, and its length is a parameter.

Top module: `fsel_watchdog`

## Requirements
- R1: While `pwrgd_n` is 0, the latch copies `hw_fsel` on every clock. While `pwrgd_n` is 1, the latch keeps its value, whatever `hw_fsel` does.
- R2: Outside alarm, `fsel_out` shows `reg_fsel` when `fsel_src` is 1 and the latched pins when `fsel_src` is 0. It is registered, so it updates on the first clock edge after its inputs change. This choice works whatever the value of `prog_en`.
- R3: With the watchdog active and a count N of 1 or more, `alarm` reads 1 exactly N×TICK_DIV clock edges after the first edge at which the watchdog is active, or after the last reload.
- R4: The watchdog is active only when `prog_en` and `wd_en` are both 1. When it is inactive, the timer is held at the count value and `alarm` never sets.
- R5: A pulse on `wd_count_wr` reloads the timer from `wd_count` and restarts the tick prescaler. The next timeout is then a full N×TICK_DIV edges later.
- R6: While `alarm` is 1, `fsel_out` shows the safe code, one edge after the alarm is set. The safe code is `safe_fsel` when `safe_src` and `prog_en` are both 1; in every other case it is the latched pins.
- R7: `alarm` stays 1 until a clock edge at which `alarm_clr` is 1. After that edge, `fsel_out` goes back to the normal selection.
- R8: A timeout drives `sys_rst_n` low from the expiry edge for exactly RST_TICKS×TICK_DIV clock edges. After that, `sys_rst_n` returns to 1.
- R9: When `chg_rst_en` is 1 and the power-good strobe has been 1 for at least one edge, any change of the registered code starts the same reset pulse. When `chg_rst_en` is 0, a code change leaves `sys_rst_n` at 1.
- R10: When `prog_en` is 0, the safe code is always the latched pins, even if `safe_src` is 1. A stored alarm is still honoured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrgd_n | input | 1 | Active-low power-good strobe; pins are sampled while it is low |
| hw_fsel | input | 5 | Hardware frequency-select pins |
| prog_en | input | 1 | Master enable for programmed overrides |
| fsel_src | input | 1 | 1 = register code, 0 = latched pins |
| reg_fsel | input | 5 | Programmed frequency code |
| wd_en | input | 1 | Watchdog enable |
| wd_count | input | 8 | Timeout in ticks |
| wd_count_wr | input | 1 | Write strobe of the count field (reload) |
| safe_src | input | 1 | 1 = programmed safe field, 0 = latched pins |
| safe_fsel | input | 5 | Programmed safe code |
| alarm_clr | input | 1 | Software write of 0 to the alarm bit |
| chg_rst_en | input | 1 | Enable reset pulse on a code change |
| fsel_out | output | 5 | Active frequency-select code |
| alarm | output | 1 | Sticky watchdog alarm status |
| sys_rst_n | output | 1 | Active-low system reset pulse |

## Verification
Each result has a fixed latency:

- The code output and the alarm flag follow their cause at the next clock edge. The exception is the safe code, which needs one more edge after the alarm.
- A timeout lands exactly N×TICK_DIV edges after the enabling edge or the reload edge.
- The reset line falls at the trigger edge and rises RST_TICKS×TICK_DIV edges later.

The bench drives every input on the falling edge and counts rising edges from the edge that takes the stimulus. For each timed result it samples both the last edge before the expected change and the edge on which the change is due. In this way an error of one cycle in either direction is caught.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
  localparam int FCODE_W = 5;
  typedef logic [FCODE_W-1:0] fcode_t;
endpackage

// File: rtl/fsw_prescaler.sv
module fsw_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic restart,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)       cnt_d = '0;
    else if (en) begin
      if (cnt_q == LAST) cnt_d = '0;
      else               cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = en && !restart && (cnt_q == LAST);

  // R3: the divider never leaves its range
  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/fsw_timer.sv
module fsw_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic             alarm_clr,
  output logic             expire,
  output logic             alarm
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             alarm_q, alarm_d;

  assign expire = run && tick && !load && (cnt_q <= CNT_W'(1));

  always_comb begin
    cnt_d   = cnt_q;
    alarm_d = alarm_q;
    if (alarm_clr) alarm_d = 1'b0;
    if (load) begin
      cnt_d = load_val;
    end else if (run && tick) begin
      if (expire) begin
        cnt_d   = load_val;
        alarm_d = 1'b1;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      alarm_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      alarm_q <= alarm_d;
    end
  end

  assign alarm = alarm_q;

  // R7: alarm is sticky until cleared
  assert_alarm_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_q && !alarm_clr |=> alarm_q);
  // R4: alarm can only rise while the timer runs
  assert_alarm_needs_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_q) |-> $past(run));
endmodule

// File: rtl/fsw_rstgen.sv
module fsw_rstgen #(
  parameter int TICK_DIV  = 4,
  parameter int RST_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic sys_rst_n
);
  localparam int TW = $clog2(RST_TICKS + 1);
  localparam logic [TW-1:0] TLAST = TW'(RST_TICKS - 1);

  logic          busy_q, busy_d;
  logic [TW-1:0] tcnt_q, tcnt_d;
  logic          ptick;

  fsw_prescaler #(.DIV(TICK_DIV)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (busy_q),
    .restart (trig),
    .tick    (ptick)
  );

  always_comb begin
    busy_d = busy_q;
    tcnt_d = tcnt_q;
    if (trig) begin
      busy_d = 1'b1;
      tcnt_d = '0;
    end else if (busy_q && ptick) begin
      if (tcnt_q == TLAST) busy_d = 1'b0;
      else                 tcnt_d = tcnt_q + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tcnt_q <= '0;
    end else begin
      busy_q <= busy_d;
      tcnt_q <= tcnt_d;
    end
  end

  assign sys_rst_n = !busy_q;

  // R8: a trigger pulls the reset line low at the next edge
  assert_trig_pulls_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !sys_rst_n);
endmodule

// File: rtl/fsel_watchdog.sv
module fsel_watchdog
  import fsw_pkg::*;
#(
  parameter int TICK_DIV  = 4152220,
  parameter int CNT_W     = 8,
  parameter int RST_TICKS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwrgd_n,
  input  logic [FCODE_W-1:0] hw_fsel,
  input  logic               prog_en,
  input  logic               fsel_src,
  input  logic [FCODE_W-1:0] reg_fsel,
  input  logic               wd_en,
  input  logic [CNT_W-1:0]   wd_count,
  input  logic               wd_count_wr,
  input  logic               safe_src,
  input  logic [FCODE_W-1:0] safe_fsel,
  input  logic               alarm_clr,
  input  logic               chg_rst_en,
  output logic [FCODE_W-1:0] fsel_out,
  output logic               alarm,
  output logic               sys_rst_n
);
  fcode_t hw_lat_q;
  logic   pg_q;
  fcode_t fsel_q, fsel_d, normal_code, safe_code;
  logic   wd_active, run, load, tick, expire, alarm_i, chg, trig;

  // pin latch, clock-enabled by the power-good strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hw_lat_q <= '0;
    else if (!pwrgd_n) hw_lat_q <= hw_fsel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pg_q <= 1'b0;
    else        pg_q <= pwrgd_n;
  end

  assign wd_active   = prog_en && wd_en;
  assign run         = wd_active && !alarm_i;
  assign load        = wd_count_wr || !wd_active;
  assign normal_code = fsel_src ? fcode_t'(reg_fsel) : hw_lat_q;
  assign safe_code   = (prog_en && safe_src) ? fcode_t'(safe_fsel) : hw_lat_q;

  always_comb begin
    fsel_d = alarm_i ? safe_code : normal_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fsel_q <= '0;
    else        fsel_q <= fsel_d;
  end

  assign chg  = chg_rst_en && pg_q && pwrgd_n && (fsel_d != fsel_q);
  assign trig = expire || chg;

  fsw_prescaler #(.DIV(TICK_DIV)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (run),
    .restart (load || !run),
    .tick    (tick)
  );

  fsw_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .load      (load),
    .load_val  (wd_count),
    .tick      (tick),
    .alarm_clr (alarm_clr),
    .expire    (expire),
    .alarm     (alarm_i)
  );

  fsw_rstgen #(.TICK_DIV(TICK_DIV), .RST_TICKS(RST_TICKS)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig      (trig),
    .sys_rst_n (sys_rst_n)
  );

  assign fsel_out = fsel_q;
  assign alarm    = alarm_i;

  // R1: latched pins hold once power-good is high
  assert_latch_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pwrgd_n |=> $stable(hw_lat_q));
  // R6: during an alarm the output carries the safe code
  assert_safe_in_alarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_i |=> fsel_q == $past(safe_code));
  // R4: no expiry without an active watchdog
  assert_no_expire_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_en && wd_en) |=> !$rose(alarm_i));
endmodule

// File: tb/sim_fsel_watchdog.sv
module sim_fsel_watchdog;
  localparam int DIV = 4;
  localparam int RT  = 2;

  logic       clk = 1'b0;
  logic       rst_n, pwrgd_n, prog_en, fsel_src, wd_en, wd_count_wr;
  logic       safe_src, alarm_clr, chg_rst_en;
  logic [4:0] hw_fsel, reg_fsel, safe_fsel, fsel_out;
  logic [7:0] wd_count;
  logic       alarm, sys_rst_n;
  int         n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  fsel_watchdog #(.TICK_DIV(DIV), .CNT_W(8), .RST_TICKS(RT)) u0 (
    .clk(clk), .rst_n(rst_n), .pwrgd_n(pwrgd_n), .hw_fsel(hw_fsel),
    .prog_en(prog_en), .fsel_src(fsel_src), .reg_fsel(reg_fsel),
    .wd_en(wd_en), .wd_count(wd_count), .wd_count_wr(wd_count_wr),
    .safe_src(safe_src), .safe_fsel(safe_fsel), .alarm_clr(alarm_clr),
    .chg_rst_en(chg_rst_en), .fsel_out(fsel_out), .alarm(alarm),
    .sys_rst_n(sys_rst_n));

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input int got, input int exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic t_reset_and_latch();
    rst_n = 0; pwrgd_n = 0; hw_fsel = 5'h0A; prog_en = 0; fsel_src = 0;
    reg_fsel = 5'h11; wd_en = 0; wd_count = 8'd3; wd_count_wr = 0;
    safe_src = 0; safe_fsel = 5'h0F; alarm_clr = 0; chg_rst_en = 0;
    step(3);
    check("reset fsel_out", fsel_out, 0);
    check("reset alarm", alarm, 0);
    check("reset sys_rst_n", sys_rst_n, 1);
    rst_n = 1;
    step(2);
    pwrgd_n = 1;
    step(1);
    hw_fsel = 5'h15;
    step(3);
    check("R1 latched pins held", fsel_out, 5'h0A);
  endtask

  task automatic t_select();
    fsel_src = 1;
    step(1);
    check("R2 register code", fsel_out, 5'h11);
    fsel_src = 0;
    step(1);
    check("R2 latched code", fsel_out, 5'h0A);
    check("R9 no pulse when disabled", sys_rst_n, 1);
  endtask

  task automatic t_timeout();
    prog_en = 1; safe_src = 1; safe_fsel = 5'h0F; wd_count = 8'd3;
    step(1);
    wd_en = 1;
    step(3 * DIV - 1);
    check("R3 no alarm before N*DIV", alarm, 0);
    step(1);
    check("R3 alarm at N*DIV", alarm, 1);
    check("R8 reset low at expiry", sys_rst_n, 0);
    step(1);
    check("R6 programmed safe code", fsel_out, 5'h0F);
    step(RT * DIV - 2);
    check("R8 reset still low", sys_rst_n, 0);
    step(1);
    check("R8 reset released", sys_rst_n, 1);
  endtask

  task automatic t_sticky();
    step(20);
    check("R7 alarm sticky", alarm, 1);
    check("R6 safe code held", fsel_out, 5'h0F);
    wd_en = 0; alarm_clr = 1;
    step(1);
    alarm_clr = 0;
    check("R7 alarm cleared", alarm, 0);
    step(1);
    check("R7 normal code back", fsel_out, 5'h0A);
  endtask

  task automatic t_keepalive();
    wd_count = 8'd3;
    step(1);
    wd_en = 1;
    step(10);
    wd_count_wr = 1;
    step(1);
    wd_count_wr = 0;
    step(3 * DIV - 1);
    check("R5 reload postpones timeout", alarm, 0);
    step(1);
    check("R5 timeout after reload", alarm, 1);
    wd_en = 0; alarm_clr = 1;
    step(1);
    alarm_clr = 0;
    step(RT * DIV + 2);
  endtask

  task automatic t_disabled();
    prog_en = 0; wd_en = 1; wd_count = 8'd1;
    step(40);
    check("R4 no alarm without prog_en", alarm, 0);
    prog_en = 1; wd_en = 0;
    step(40);
    check("R4 no alarm without wd_en", alarm, 0);
  endtask

  task automatic t_progen_safe();
    safe_src = 1; safe_fsel = 5'h07; wd_count = 8'd1;
    step(1);
    wd_en = 1;
    step(DIV);
    check("R3 one-tick timeout", alarm, 1);
    step(1);
    check("R6 safe field used", fsel_out, 5'h07);
    prog_en = 0;
    step(1);
    check("R10 latched safe code", fsel_out, 5'h0A);
    check("R10 alarm kept", alarm, 1);
    wd_en = 0; alarm_clr = 1;
    step(1);
    alarm_clr = 0;
    step(RT * DIV + 2);
  endtask

  task automatic t_change_reset();
    chg_rst_en = 1;
    step(2);
    check("R9 idle line high", sys_rst_n, 1);
    fsel_src = 1;
    step(1);
    check("R9 pulse on change", sys_rst_n, 0);
    check("R2 code follows", fsel_out, 5'h11);
    step(RT * DIV - 1);
    check("R9 pulse still low", sys_rst_n, 0);
    step(1);
    check("R9 pulse ends", sys_rst_n, 1);
    chg_rst_en = 0;
  endtask

  initial begin
    fork
      begin
        t_reset_and_latch();
        t_select();
        t_timeout();
        t_sticky();
        t_keepalive();
        t_disabled();
        t_progen_safe();
        t_change_reset();
      end
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got hang expected completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule